// File: doc/BRIEF.md
# Software Style Configuration Register

This block holds the controller's software style selector, an 8-bit code that tells the bus-master logic how wide the shared memory structures are. Style codes 2 and 3 mean 32-bit structures. Every other code means 16-bit structures. The block derives a read-only wide-structure flag from the code. It also keeps an advanced parity enable bit, which software may change only while the controller is stopped or suspended.

The block uses the wide flag in two places. The first is master address forming: a 32-bit pointer passes through as it is, while a 24-bit pointer is extended with a stored upper byte. The second is parity flagging: a data parity error seen during a master access raises a one-cycle request to set the error bit in the current descriptor's status word. That request is raised only when the enable bit is set and the block is in wide mode.

The pointer-to-address path is a valid/ready stream with no storage. The output valid follows the input valid, and the input ready follows the output ready. A pointer transfers in the cycle where both are high. The address bus is driven at all times, including cycles where valid is low. The register port and the status inputs are plain signals.

Top module: `swstyle_ctrl`

## Requirements
- R1: While `rst_n` is low, `reg_rdata` reads 0 and `desc_perr` is 0.
- R2: A write (`reg_wr` high at a clock edge) loads `reg_wdata[7:0]` into the style field at any time. The style field reads back on `reg_rdata[7:0]`.
- R3: `reg_rdata[8]` reads 1 exactly when the style field holds 2 or 3. Writes to bit 8 are ignored.
- R4: The parity enable, read on `reg_rdata[10]`, is loaded from `reg_wdata[10]` by a write only when `stop_st` or `spnd_st` is high. A write with both low leaves it unchanged.
- R5: A pulse on `soft_rst` and a high `stop_st` without a write leave the whole register contents unchanged.
- R6: Bits 9 and 31:11 of `reg_rdata` always read 0, whatever is written to them.
- R7: With `reg_rdata[8]` = 0, `addr_data` = {`upper_byte`, `ptr_data[23:0]`}.
- R8: With `reg_rdata[8]` = 1, `addr_data` = `ptr_data`.
- R9: `addr_valid` equals `ptr_valid` and `ptr_ready` equals `addr_ready` in every cycle. There is no buffering.
- R10: `desc_perr` is high for exactly the cycle after an edge at which `perr_strobe`, `perr_master`, the parity enable and the wide flag were all high. Otherwise it is low. This includes target-side errors, where `perr_master` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Hard reset, asynchronous, active low |
| soft_rst | input | 1 | Soft reset; has no effect on this register |
| stop_st | input | 1 | Controller stopped |
| spnd_st | input | 1 | Controller suspended |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data |
| ptr_valid | input | 1 | Pointer valid |
| ptr_ready | output | 1 | Pointer ready |
| ptr_data | input | 32 | Pointer from the shared structures |
| upper_byte | input | 8 | Stored upper address byte |
| addr_valid | output | 1 | Master address valid |
| addr_ready | input | 1 | Master address ready |
| addr_data | output | 32 | Master address |
| perr_strobe | input | 1 | Data parity error seen |
| perr_master | input | 1 | The error happened during a master access |
| desc_perr | output | 1 | Request to set the descriptor status error bit |

## Verification
The hardest state to reach from the ports has the parity enable set while the style code is a 16-bit mode. The enable can only be set while stopped or suspended, and the style must then be changed by a later write. The stimulus therefore sets the enable under `stop_st` in style 2. It next rewrites the style to 1 with `stop_st` low and a zero in bit 10, so the enable survives. It then fires master parity errors, which must not produce `desc_perr`. A long pseudo-random phase follows, with writes, gating inputs and strobes, against a behavioural model that is checked on every clock.

// File: rtl/swstyle_pkg.sv
package swstyle_pkg;
  localparam int STYLE_W  = 8;
  localparam int WIDE_BIT = 8;
  localparam int PEN_BIT  = 10;

  function automatic logic style_is_wide(input logic [STYLE_W-1:0] code);
    return (code == STYLE_W'(2)) || (code == STYLE_W'(3));
  endfunction
endpackage

// File: rtl/swstyle_regs.sv
module swstyle_regs
  import swstyle_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [DATA_W-1:0]  wdata,
  input  logic               stop_st,
  input  logic               spnd_st,
  output logic [STYLE_W-1:0] style_q,
  output logic               pen_q,
  output logic               wide
);
  logic pen_gate;
  assign pen_gate = stop_st | spnd_st;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      style_q <= '0;
      pen_q   <= 1'b0;
    end else if (wr_en) begin
      style_q <= wdata[STYLE_W-1:0];
      if (pen_gate) pen_q <= wdata[PEN_BIT];
    end
  end

  assign wide = style_is_wide(style_q);

  AST_STYLE_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> style_q == $past(wdata[STYLE_W-1:0])); // R2
  AST_PEN_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    (!stop_st && !spnd_st) |=> $stable(pen_q)); // R4
endmodule

// File: rtl/swstyle_addr.sv
module swstyle_addr #(
  parameter int ADDR_W = 32,
  parameter int LOW_W  = 24
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wide,
  input  logic                    ptr_valid,
  output logic                    ptr_ready,
  input  logic [ADDR_W-1:0]       ptr_data,
  input  logic [ADDR_W-LOW_W-1:0] upper_byte,
  output logic                    addr_valid,
  input  logic                    addr_ready,
  output logic [ADDR_W-1:0]       addr_data
);
  localparam int HI_W = ADDR_W - LOW_W;

  assign addr_valid = ptr_valid;
  assign ptr_ready  = addr_ready;
  assign addr_data[LOW_W-1:0] = ptr_data[LOW_W-1:0];

  generate
    if (HI_W > 0) begin : g_upper
      assign addr_data[ADDR_W-1:LOW_W] = wide ? ptr_data[ADDR_W-1:LOW_W] : upper_byte;
    end
  endgenerate

  AST_NARROW_UPPER: assert property (@(posedge clk) disable iff (!rst_n)
    !wide |-> addr_data[ADDR_W-1:LOW_W] == upper_byte); // R7
  AST_WIDE_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    wide |-> addr_data == ptr_data); // R8
endmodule

// File: rtl/swstyle_perr.sv
module swstyle_perr (
  input  logic clk,
  input  logic rst_n,
  input  logic perr_strobe,
  input  logic perr_master,
  input  logic pen,
  input  logic wide,
  output logic desc_perr
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) desc_perr <= 1'b0;
    else        desc_perr <= perr_strobe & perr_master & pen & wide;
  end

  AST_PERR_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    desc_perr |-> $past(perr_strobe && perr_master && pen && wide)); // R10
  AST_PERR_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
    !perr_master |=> !desc_perr); // R10
endmodule

// File: rtl/swstyle_ctrl.sv
module swstyle_ctrl
  import swstyle_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 32,
  parameter int LOW_W  = 24
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    soft_rst,
  input  logic                    stop_st,
  input  logic                    spnd_st,
  input  logic                    reg_wr,
  input  logic [DATA_W-1:0]       reg_wdata,
  output logic [DATA_W-1:0]       reg_rdata,
  input  logic                    ptr_valid,
  output logic                    ptr_ready,
  input  logic [ADDR_W-1:0]       ptr_data,
  input  logic [ADDR_W-LOW_W-1:0] upper_byte,
  output logic                    addr_valid,
  input  logic                    addr_ready,
  output logic [ADDR_W-1:0]       addr_data,
  input  logic                    perr_strobe,
  input  logic                    perr_master,
  output logic                    desc_perr
);
  logic [STYLE_W-1:0] style_q;
  logic               pen_q;
  logic               wide;

  swstyle_regs #(.DATA_W(DATA_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(reg_wr), .wdata(reg_wdata),
    .stop_st(stop_st), .spnd_st(spnd_st),
    .style_q(style_q), .pen_q(pen_q), .wide(wide)
  );

  swstyle_addr #(.ADDR_W(ADDR_W), .LOW_W(LOW_W)) u_addr (
    .clk(clk), .rst_n(rst_n), .wide(wide),
    .ptr_valid(ptr_valid), .ptr_ready(ptr_ready), .ptr_data(ptr_data),
    .upper_byte(upper_byte), .addr_valid(addr_valid),
    .addr_ready(addr_ready), .addr_data(addr_data)
  );

  swstyle_perr u_perr (
    .clk(clk), .rst_n(rst_n), .perr_strobe(perr_strobe),
    .perr_master(perr_master), .pen(pen_q), .wide(wide),
    .desc_perr(desc_perr)
  );

  always_comb begin
    reg_rdata = '0;
    reg_rdata[STYLE_W-1:0] = style_q;
    reg_rdata[WIDE_BIT]    = wide;
    reg_rdata[PEN_BIT]     = pen_q;
  end

  AST_SOFT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    ((soft_rst || stop_st) && !reg_wr) |=> $stable(reg_rdata)); // R5
  AST_STREAM_TIE: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_valid == ptr_valid) && (ptr_ready == addr_ready)); // R9
endmodule

// File: tb/swstyle_ctrl_test.sv
`timescale 1ns/1ps
module swstyle_ctrl_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        soft_rst = 0, stop_st = 0, spnd_st = 0, reg_wr = 0;
  logic [31:0] reg_wdata = '0, ptr_data = '0;
  logic [7:0]  upper_byte = '0;
  logic        ptr_valid = 0, addr_ready = 0, perr_strobe = 0, perr_master = 0;
  logic [31:0] reg_rdata, addr_data;
  logic        ptr_ready, addr_valid, desc_perr;

  int checks = 0, fails = 0;
  bit done = 0;

  int m_style = 0;
  bit m_pen = 0, m_perr = 0;

  always #2.5 clk = ~clk;

  swstyle_ctrl uut (
    .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .stop_st(stop_st),
    .spnd_st(spnd_st), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .ptr_valid(ptr_valid), .ptr_ready(ptr_ready),
    .ptr_data(ptr_data), .upper_byte(upper_byte), .addr_valid(addr_valid),
    .addr_ready(addr_ready), .addr_data(addr_data),
    .perr_strobe(perr_strobe), .perr_master(perr_master), .desc_perr(desc_perr)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic bit m_wide();
    return (m_style == 2) || (m_style == 3);
  endfunction

  task automatic compare_all();
    logic [31:0] ea;
    chk("R2 style field", {24'b0, reg_rdata[7:0]}, m_style);
    chk("R3 wide flag", {31'b0, reg_rdata[8]}, {31'b0, m_wide()});
    chk("R4 parity enable", {31'b0, reg_rdata[10]}, {31'b0, m_pen});
    chk("R6 reserved bits", reg_rdata & 32'hFFFF_FA00, 32'h0);
    if (m_wide()) begin
      ea = ptr_data;
      chk("R8 wide address", addr_data, ea);
    end else begin
      ea = {upper_byte, ptr_data[23:0]};
      chk("R7 narrow address", addr_data, ea);
    end
    chk("R9 handshake", {30'b0, addr_valid, ptr_ready}, {30'b0, ptr_valid, addr_ready});
    chk("R10 descriptor flag", {31'b0, desc_perr}, {31'b0, m_perr});
  endtask

  task automatic cycle();
    @(posedge clk);
    m_perr = perr_strobe && perr_master && m_pen && m_wide();
    if (reg_wr) begin
      m_style = reg_wdata[7:0];
      if (stop_st || spnd_st) m_pen = reg_wdata[10];
    end
    @(negedge clk);
    compare_all();
  endtask

  task automatic drive(input bit wr, input logic [31:0] wd, input bit st, input bit sp,
                       input bit sr, input bit ps, input bit pm);
    reg_wr = wr; reg_wdata = wd; stop_st = st; spnd_st = sp; soft_rst = sr;
    perr_strobe = ps; perr_master = pm;
    cycle();
  endtask

  initial begin
    ptr_data = 32'hA1B2_C3D4; upper_byte = 8'h5E; ptr_valid = 1; addr_ready = 0;
    reg_wr = 1; reg_wdata = 32'hFFFF_FFFF; stop_st = 1; perr_strobe = 1; perr_master = 1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1 reset rdata", reg_rdata, 32'h0);
    chk("R1 reset flag", {31'b0, desc_perr}, 32'h0);
    chk("R7 narrow address in reset state", addr_data, 32'h5EB2_C3D4);
    reg_wr = 0; perr_strobe = 0; stop_st = 0;
    rst_n = 1;
    cycle();
    drive(1, 32'h0000_0402, 0, 0, 0, 0, 0);
    chk("R4 locked write", {31'b0, reg_rdata[10]}, 32'h0);
    drive(1, 32'hFFFF_FF02, 1, 0, 0, 0, 0);
    chk("R6 reserved after ones", reg_rdata, 32'h0000_0502);
    drive(0, 0, 0, 0, 0, 1, 1);
    chk("R10 pulse set", {31'b0, desc_perr}, 32'h1);
    drive(0, 0, 0, 0, 0, 0, 0);
    chk("R10 pulse ends", {31'b0, desc_perr}, 32'h0);
    drive(0, 0, 0, 0, 0, 1, 0);
    chk("R10 target error", {31'b0, desc_perr}, 32'h0);
    drive(0, 0, 0, 0, 1, 0, 0);
    drive(0, 0, 1, 0, 0, 0, 0);
    chk("R5 soft reset and stop hold", reg_rdata, 32'h0000_0502);
    drive(1, 32'h0000_0001, 0, 0, 0, 0, 0);
    chk("R4 enable survives narrow style", reg_rdata, 32'h0000_0401);
    drive(0, 0, 0, 0, 0, 1, 1);
    chk("R10 narrow mode no flag", {31'b0, desc_perr}, 32'h0);
    drive(1, 32'h0000_0103, 0, 1, 0, 0, 0);
    chk("R3 style 3 wide, bit 8 ignored", reg_rdata, 32'h0000_0103);
    chk("R8 wide address", addr_data, 32'hA1B2_C3D4);
    drive(1, 32'h0000_0004, 0, 0, 0, 0, 0);
    chk("R3 style 4 narrow", {31'b0, reg_rdata[8]}, 32'h0);
    for (int i = 0; i < 4000; i++) begin
      ptr_data = $urandom; upper_byte = 8'($urandom);
      ptr_valid = 1'($urandom); addr_ready = 1'($urandom);
      drive(($urandom % 4) == 0, ($urandom % 2) ? ($urandom & 32'h0000_0403) : $urandom,
            ($urandom % 3) == 0, ($urandom % 5) == 0, ($urandom % 7) == 0,
            1'($urandom), 1'($urandom));
    end
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule